// File: doc/BRIEF.md
# Global Timer with Self-Rearming Comparator

This block holds a 64-bit free-running counter and one 64-bit comparator behind a small 32-bit register bus. When the counter runs and reaches the comparator value, a match flag is set and, if the interrupt is enabled, the interrupt line goes high. With auto-increment on, each match also adds a programmed step to the comparator, so the match recurs every step counts and the block acts as a periodic tick source. Software clears the match flag by writing one to it.

Writes to the counter halves, the comparator halves, the step register and the control register do not act at once. Each is held in a staging slot and commits a fixed number of cycles later. At that edge a sticky write-done flag for that register is set, and software clears it by writing one. The counter carries from its low half into its high half in the same cycle. Software can therefore read high, low, then high again and retry if the two high reads differ.

The request side is valid/ready. `bus_ready` is tied high, so every request is taken in the cycle `bus_valid` is high. Read data comes back on `rd_valid`/`rd_data` exactly one cycle after the read is taken. That return path has no back-pressure: the requester must capture it in that cycle.

Top module: `gtimer_core`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low. This covers the counter, comparator, step, control, interrupt enable, interrupt flag and both write-done registers.
- R2: With the run bit (control bit 0) set, the counter rises by exactly 1 each cycle and carries from bit 31 into bit 32 in the same cycle. With the run bit clear, the counter holds.
- R3: A write to counter low (addr 0) or counter high (addr 1) leaves the counter unchanged for 4 cycles. The new half takes effect at the 4th rising edge after the write is accepted. At that same edge, bit 0 (low) or bit 1 (high) of the counter write-done register (addr 2) is set.
- R4: Writes to comparator low (addr 3), comparator high (addr 4), step (addr 5) and control (addr 6) commit 4 edges after acceptance. Each sets its own bit of the global write-done register (addr 7): bits 0, 1, 2 and 3 respectively.
- R5: In both write-done registers, writing 1 to a bit clears it. Writing 0 to a bit leaves it unchanged.
- R6: Writes to the interrupt-enable (addr 8), interrupt-flag (addr 9) or write-done registers take effect at once and set no write-done bit.
- R7: When the run bit and the compare-enable bit (control bit 1) are both set and the counter equals the comparator, bit 0 of the interrupt-flag register is set at the next edge. With compare-enable clear, no match is flagged.
- R8: With auto-increment (control bit 2) set, each match adds the step register to the comparator. Successive flags are then exactly step cycles apart.
- R9: `irq_o` is high exactly when the interrupt flag and bit 0 of interrupt-enable are both set. Writing 1 to flag bit 0 clears the flag; writing 0 does not. A match in the same cycle as a clear wins.
- R10: `bus_ready` is always high. A read accepted at an edge gives `rd_valid` high for one cycle after that edge, with `rd_data` holding the register value from before that edge. Writes give no `rd_valid`.
- R11: With auto-increment clear, a match leaves the comparator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Request accepted (tied high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after acceptance |
| rd_data | output | 32 | Read data |
| irq_o | output | 1 | Match interrupt, flag AND enable |

## Verification
A stuck or miscounted staging slot shows up within a few cycles as a write-done bit that rises at the wrong edge. The bench catches this by reading the write-done register at the edge just before commit and again just after. A wrong carry or a bad increment shows in the next high/low read pair. A comparator that rearms wrongly shows as the wrong spacing between two interrupt flags, which is found within one period. It also shows as a wrong comparator readback right after the second match.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam int DW = 32;
  localparam int AW = 4;

  localparam logic [AW-1:0] A_CNT_LO  = 4'd0;
  localparam logic [AW-1:0] A_CNT_HI  = 4'd1;
  localparam logic [AW-1:0] A_CNT_WST = 4'd2;
  localparam logic [AW-1:0] A_CMP_LO  = 4'd3;
  localparam logic [AW-1:0] A_CMP_HI  = 4'd4;
  localparam logic [AW-1:0] A_STEP    = 4'd5;
  localparam logic [AW-1:0] A_CTRL    = 4'd6;
  localparam logic [AW-1:0] A_GL_WST  = 4'd7;
  localparam logic [AW-1:0] A_IRQ_EN  = 4'd8;
  localparam logic [AW-1:0] A_IRQ_FLG = 4'd9;

  // staging slot indices; global write-done bits follow slots 2..5 in order
  localparam int SL_CNT_LO = 0;
  localparam int SL_CNT_HI = 1;
  localparam int SL_CMP_LO = 2;
  localparam int SL_CMP_HI = 3;
  localparam int SL_STEP   = 4;
  localparam int SL_CTRL   = 5;
  localparam int NSLOT     = 6;

  localparam logic [AW-1:0] SLOT_ADDR [NSLOT] =
    '{A_CNT_LO, A_CNT_HI, A_CMP_LO, A_CMP_HI, A_STEP, A_CTRL};

  typedef struct packed {
    logic auto_inc;
    logic cmp_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/gt_commit_slot.sv
module gt_commit_slot #(
  parameter int W   = 32,
  parameter int LAT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         fire,
  output logic [W-1:0] dout
);
  localparam int CW = $clog2(LAT + 1);

  logic          pend_q;
  logic [CW-1:0] left_q;
  logic [W-1:0]  data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      left_q <= '0;
      data_q <= '0;
    end else if (load) begin
      pend_q <= 1'b1;
      left_q <= CW'(LAT - 1);
      data_q <= din;
    end else if (pend_q) begin
      if (left_q == '0) pend_q <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  assign fire = pend_q && (left_q == '0);
  assign dout = data_q;
endmodule

// File: rtl/gt_counter.sv
module gt_counter #(
  parameter int HW = 32,
  localparam int W = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [HW-1:0] lo_val,
  input  logic [HW-1:0] hi_val,
  output logic [W-1:0]  cnt
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = run ? cnt + W'(1) : cnt;
    if (ld_lo) nxt[HW-1:0] = lo_val;
    if (ld_hi) nxt[W-1:HW] = hi_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end
endmodule

// File: rtl/gt_comparator.sv
module gt_comparator #(
  parameter int HW = 32,
  localparam int W = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  cnt,
  input  logic          run,
  input  logic          cmp_en,
  input  logic          auto_inc,
  input  logic [HW-1:0] step,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [HW-1:0] lo_val,
  input  logic [HW-1:0] hi_val,
  output logic [W-1:0]  cmp,
  output logic          hit
);
  logic [W-1:0] nxt;

  assign hit = run && cmp_en && (cnt == cmp);

  always_comb begin
    nxt = (hit && auto_inc) ? cmp + {{HW{1'b0}}, step} : cmp;
    if (ld_lo) nxt[HW-1:0] = lo_val;
    if (ld_hi) nxt[W-1:HW] = hi_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp <= '0;
    else        cmp <= nxt;
  end
endmodule

// File: rtl/gt_regif.sv
module gt_regif
  import gt_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [AW-1:0]            bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  output logic                     rd_valid,
  output logic [DW-1:0]            rd_data,
  input  logic [2*DW-1:0]          cnt,
  input  logic [2*DW-1:0]          cmp,
  input  logic                     hit,
  output logic [NSLOT-1:0]         fire,
  output logic [NSLOT-1:0][DW-1:0] slot_data,
  output logic [DW-1:0]            step,
  output ctrl_t                    ctrl,
  output logic                     irq_en,
  output logic                     irq_flag,
  output logic                     irq_o
);
  logic       wr;
  logic       rd;
  logic [1:0] cnt_wst;
  logic [3:0] gl_wst;
  logic [1:0] cnt_wst_clr;
  logic [3:0] gl_wst_clr;

  assign wr = bus_valid && bus_write;
  assign rd = bus_valid && !bus_write;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    gt_commit_slot #(.W(DW), .LAT(LAT)) slot_i (
      .clk  (clk),
      .rst_n(rst_n),
      .load (wr && (bus_addr == SLOT_ADDR[g])),
      .din  (bus_wdata),
      .fire (fire[g]),
      .dout (slot_data[g])
    );
  end

  assign cnt_wst_clr = (wr && bus_addr == A_CNT_WST) ? bus_wdata[1:0] : 2'b00;
  assign gl_wst_clr  = (wr && bus_addr == A_GL_WST)  ? bus_wdata[3:0] : 4'b0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_wst  <= '0;
      gl_wst   <= '0;
      step     <= '0;
      ctrl     <= '0;
      irq_en   <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      cnt_wst <= (cnt_wst & ~cnt_wst_clr) | fire[SL_CNT_HI:SL_CNT_LO];
      gl_wst  <= (gl_wst & ~gl_wst_clr) | fire[SL_CTRL:SL_CMP_LO];
      if (fire[SL_STEP]) step <= slot_data[SL_STEP];
      if (fire[SL_CTRL]) ctrl <= ctrl_t'(slot_data[SL_CTRL][2:0]);
      if (wr && bus_addr == A_IRQ_EN) irq_en <= bus_wdata[0];
      if (hit)
        irq_flag <= 1'b1;
      else if (wr && bus_addr == A_IRQ_FLG && bus_wdata[0])
        irq_flag <= 1'b0;
    end
  end

  assign irq_o = irq_flag & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      if (rd) begin
        case (bus_addr)
          A_CNT_LO:  rd_data <= cnt[DW-1:0];
          A_CNT_HI:  rd_data <= cnt[2*DW-1:DW];
          A_CNT_WST: rd_data <= DW'(cnt_wst);
          A_CMP_LO:  rd_data <= cmp[DW-1:0];
          A_CMP_HI:  rd_data <= cmp[2*DW-1:DW];
          A_STEP:    rd_data <= step;
          A_CTRL:    rd_data <= DW'(ctrl);
          A_GL_WST:  rd_data <= DW'(gl_wst);
          A_IRQ_EN:  rd_data <= DW'(irq_en);
          A_IRQ_FLG: rd_data <= DW'(irq_flag);
          default:   rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gtimer_core.sv
module gtimer_core
  import gt_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  output logic          bus_ready,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          irq_o
);
  logic [2*DW-1:0]          cnt;
  logic [2*DW-1:0]          cmp;
  logic                     hit;
  logic [NSLOT-1:0]         fire;
  logic [NSLOT-1:0][DW-1:0] slot_data;
  logic [DW-1:0]            step;
  ctrl_t                    ctrl;
  logic                     irq_en;
  logic                     irq_flag;
  logic                     cnt_ld;
  logic                     cmp_ld;

  assign bus_ready = 1'b1;
  assign cnt_ld = fire[SL_CNT_LO] | fire[SL_CNT_HI];
  assign cmp_ld = fire[SL_CMP_LO] | fire[SL_CMP_HI];

  gt_regif #(.LAT(LAT)) regif_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .cnt      (cnt),
    .cmp      (cmp),
    .hit      (hit),
    .fire     (fire),
    .slot_data(slot_data),
    .step     (step),
    .ctrl     (ctrl),
    .irq_en   (irq_en),
    .irq_flag (irq_flag),
    .irq_o    (irq_o)
  );

  gt_counter #(.HW(DW)) counter_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ctrl.run),
    .ld_lo (fire[SL_CNT_LO]),
    .ld_hi (fire[SL_CNT_HI]),
    .lo_val(slot_data[SL_CNT_LO]),
    .hi_val(slot_data[SL_CNT_HI]),
    .cnt   (cnt)
  );

  gt_comparator #(.HW(DW)) comparator_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt     (cnt),
    .run     (ctrl.run),
    .cmp_en  (ctrl.cmp_en),
    .auto_inc(ctrl.auto_inc),
    .step    (step),
    .ld_lo   (fire[SL_CMP_LO]),
    .ld_hi   (fire[SL_CMP_HI]),
    .lo_val  (slot_data[SL_CMP_LO]),
    .hi_val  (slot_data[SL_CMP_HI]),
    .cmp     (cmp),
    .hit     (hit)
  );
endmodule

// File: rtl/gtimer_core_sva.sv
module gtimer_core_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic        rd_valid,
  input logic        run,
  input logic        auto_inc,
  input logic        cnt_ld,
  input logic        cmp_ld,
  input logic [63:0] cnt,
  input logic [63:0] cmp,
  input logic [31:0] step,
  input logic        hit,
  input logic        irq_en,
  input logic        irq_flag,
  input logic        irq_o
);
  a_r10_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid);

  a_r10_no_stray_data: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rd_valid);

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_ld) |=> (cnt == $past(cnt) + 64'd1));

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_ld) |=> $stable(cnt));

  a_r7_hit_flags: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> irq_flag);

  a_r8_rearm_add: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && auto_inc && !cmp_ld) |=> (cmp == $past(cmp) + {32'd0, $past(step)}));

  a_r11_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !auto_inc && !cmp_ld) |=> $stable(cmp));

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_o);
endmodule

bind gtimer_core gtimer_core_sva sva_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_valid(bus_valid),
  .bus_write(bus_write),
  .rd_valid(rd_valid),
  .run     (ctrl.run),
  .auto_inc(ctrl.auto_inc),
  .cnt_ld  (cnt_ld),
  .cmp_ld  (cmp_ld),
  .cnt     (cnt),
  .cmp     (cmp),
  .step    (step),
  .hit     (hit),
  .irq_en  (irq_en),
  .irq_flag(irq_flag),
  .irq_o   (irq_o)
);

// File: tb/gtimer_core_tb_top.sv
module gtimer_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gtimer_core dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = rd_data;
    bus_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    check("R1 irq_o", 32'(irq_o), 32'd0);
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v);
      check("R1 register", v, 32'd0);
    end
  endtask

  task automatic t_read_timing();
    logic [31:0] v;
    check("R10 ready", 32'(bus_ready), 32'd1);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 4'd5;
    @(negedge clk);
    check("R10 rd_valid after accept", 32'(rd_valid), 32'd1);
    bus_valid = 1'b0;
    @(negedge clk);
    check("R10 rd_valid one cycle", 32'(rd_valid), 32'd0);
    wr(4'd8, 32'd0);
    check("R10 write no rd_valid", 32'(rd_valid), 32'd0);
    v = 0;
  endtask

  task automatic t_counter_write();
    logic [31:0] v;
    wr(4'd0, 32'hFFFF_FFFE);
    rd(4'd0, v); check("R3 low not yet", v, 32'd0);
    rd(4'd2, v); check("R3 done before 4th edge", v, 32'd0);
    rd(4'd2, v); check("R3 done after 4th edge", v, 32'd1);
    rd(4'd0, v); check("R3 low committed", v, 32'hFFFF_FFFE);
    wr(4'd1, 32'd5);
    idle(6);
    rd(4'd2, v); check("R3 both done bits", v, 32'd3);
    wr(4'd2, 32'd0);
    rd(4'd2, v); check("R5 write 0 keeps", v, 32'd3);
    wr(4'd2, 32'd1);
    rd(4'd2, v); check("R5 clear bit0", v, 32'd2);
    wr(4'd2, 32'd2);
    rd(4'd2, v); check("R5 clear bit1", v, 32'd0);
    rd(4'd1, v); check("R3 high committed", v, 32'd5);
  endtask

  task automatic t_counter_run();
    logic [31:0] v, a, b;
    wr(4'd6, 32'd1);
    idle(10);
    rd(4'd1, v); check("R2 carry into high", v, 32'd6);
    rd(4'd0, a);
    rd(4'd0, b); check("R2 step per cycle", b - a, 32'd2);
    rd(4'd1, v); check("R2 high stable", v, 32'd6);
    rd(4'd7, v); check("R4 control done bit3", v, 32'd8);
    wr(4'd6, 32'd0);
    idle(6);
    rd(4'd0, a);
    idle(3);
    rd(4'd0, b); check("R2 hold when stopped", b, a);
  endtask

  task automatic t_cfg_wstat();
    logic [31:0] v;
    wr(4'd7, 32'hF);
    rd(4'd7, v); check("R5 global clear", v, 32'd0);
    wr(4'd3, 32'd1);
    wr(4'd4, 32'd2);
    wr(4'd5, 32'd3);
    idle(6);
    rd(4'd7, v); check("R4 cmp and step bits", v, 32'd7);
    wr(4'd6, 32'd0);
    idle(6);
    rd(4'd7, v); check("R4 all four bits", v, 32'hF);
    rd(4'd4, v); check("R4 cmp high value", v, 32'd2);
    rd(4'd5, v); check("R4 step value", v, 32'd3);
    wr(4'd7, 32'hF);
    wr(4'd8, 32'd0);
    wr(4'd9, 32'd0);
    idle(6);
    rd(4'd7, v); check("R6 no global bits", v, 32'd0);
    rd(4'd2, v); check("R6 no counter bits", v, 32'd0);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    int c1, c2;
    wr(4'd0, 32'd0); wr(4'd1, 32'd0);
    wr(4'd3, 32'd20); wr(4'd4, 32'd0); wr(4'd5, 32'd10);
    wr(4'd8, 32'd1);
    idle(6);
    wr(4'd6, 32'd7);
    for (int i = 0; i < 200 && !irq_o; i++) @(negedge clk);
    check("R7 first match irq", 32'(irq_o), 32'd1);
    c1 = cyc;
    wr(4'd9, 32'd1);
    check("R9 clear drops irq", 32'(irq_o), 32'd0);
    for (int i = 0; i < 200 && !irq_o; i++) @(negedge clk);
    c2 = cyc;
    check("R8 period equals step", 32'(c2 - c1), 32'd10);
    rd(4'd3, v); check("R8 comparator rearmed", v, 32'd40);
    wr(4'd8, 32'd0);
    idle(12);
    check("R9 masked irq", 32'(irq_o), 32'd0);
    rd(4'd9, v); check("R9 flag stays set", v, 32'd1);
    wr(4'd9, 32'd0);
    rd(4'd9, v); check("R9 write 0 keeps flag", v, 32'd1);
    wr(4'd6, 32'd0);
    idle(6);
    wr(4'd9, 32'd1);
    rd(4'd9, v); check("R9 flag cleared", v, 32'd0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(4'd0, 32'd0); wr(4'd1, 32'd0);
    wr(4'd3, 32'd15); wr(4'd4, 32'd0);
    idle(6);
    wr(4'd9, 32'd1);
    wr(4'd6, 32'd3);
    idle(40);
    rd(4'd9, v); check("R7 match without auto", v, 32'd1);
    rd(4'd3, v); check("R11 comparator unchanged", v, 32'd15);
    wr(4'd9, 32'd1);
    idle(30);
    rd(4'd9, v); check("R11 no second match", v, 32'd0);
    wr(4'd6, 32'd1);
    idle(6);
    wr(4'd0, 32'd0);
    idle(40);
    rd(4'd9, v); check("R7 compare disabled", v, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired got %0d expected 0", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_read_timing();
    t_counter_write();
    t_counter_run();
    t_cfg_wstat();
    t_periodic();
    t_oneshot();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule